// File: doc/BRIEF.md
# Autonegotiation Corruption Check and Restart

This block screens the results of a finished autonegotiation before the link status is decoded. Each tick starts one check. The block fetches management registers through a simple request/acknowledge register port, which can also reach banked registers. If the control register shows autonegotiation disabled, the block stops early and reports that status decoding may go ahead. It does the same if the status register shows negotiation still incomplete.

Otherwise it reads three registers: a vendor status word in bank 1, the link partner ability word and the expansion word. The result is corrupt when the vendor "results valid" bit is low. It is also corrupt when the partner is negotiation-capable but its ability word lacks the acknowledge bit. On corruption the block writes the control register back with isolate cleared and with enable and restart both set. That write makes the PHY renegotiate.

Every check ends with exactly one single-cycle pulse. `restart_o` means a restart was written. `status_ok_o` means the normal status path may run. The register transport and the status decoding sit outside the block.

Top module: `an_guard`

## Requirements
- R1: A tick seen while idle starts a check. The first access is an unbanked read of address 0 (control).
- R2: If control bit 12 (autonegotiation enable) reads 0, the check ends with `status_ok_o` and makes no further access.
- R3: If status (address 1) bit 5 (negotiation complete) reads 0, the check ends with `status_ok_o` and makes no further access.
- R4: Otherwise three reads follow in this order: banked read of bank 1, address 12; unbanked read of address 5 (partner ability); unbanked read of address 6 (expansion).
- R5: Bit 12 of the banked word reading 0 marks the result corrupt.
- R6: Expansion bit 0 = 1 together with partner ability bit 14 = 0 marks the result corrupt. Expansion bit 0 = 0 does not mark it corrupt, whatever bit 14 holds.
- R7: On corruption, one write goes to unbanked address 0. Its value is the control word read in R1 with bit 10 cleared and bits 12 and 9 set. `restart_o` pulses the cycle after that write is acknowledged.
- R8: Each check ends with exactly one one-cycle pulse, on `restart_o` or on `status_ok_o`, never both. When no access is pending, `status_ok_o` is given for an uncorrupted result.
- R9: Ticks that arrive while a check is in progress are ignored and start no extra check.
- R10: A request stays asserted with stable address, bank, direction and data until it is acknowledged. No request is raised in a cycle that carries a result pulse.
- R11: After reset there is no request and no result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Starts a check when idle |
| mgmt_req_o | output | 1 | Register access request |
| mgmt_we_o | output | 1 | 1 = write, 0 = read |
| mgmt_banked_o | output | 1 | Access targets a banked register |
| mgmt_bank_o | output | 2 | Bank number for banked access |
| mgmt_addr_o | output | 5 | Register address |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_ack_i | input | 1 | One-cycle acknowledge of the pending request |
| mgmt_rdata_i | input | 16 | Read data, valid with acknowledge |
| restart_o | output | 1 | One-cycle pulse: restart written |
| status_ok_o | output | 1 | One-cycle pulse: status decoding may proceed |

## Verification
The assertions check, on every cycle, that the result pulses are exclusive and that no request overlaps them. They also check that a pending request holds steady until its acknowledge, that any write carries the restart shape, and that a banked access only ever targets the vendor status word. Only the bench's scenarios can show the decision itself. That covers the early exits, the order of the reads, which bit combinations count as corrupt, the exact write-back value, and that ticks during a busy check are dropped.

// File: rtl/an_guard_pkg.sv
package an_guard_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTRL, ST_RD_STAT, ST_RD_VND, ST_RD_LPA, ST_RD_EXP, ST_EVAL, ST_WR_CTRL
  } guard_st_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;
  localparam int unsigned REG_LPA  = 5;
  localparam int unsigned REG_EXP  = 6;
  localparam int unsigned VND_BANK = 1;
  localparam int unsigned VND_REG  = 12;

  localparam int unsigned BIT_AN_EN   = 12;
  localparam int unsigned BIT_RESTART = 9;
  localparam int unsigned BIT_ISO     = 10;
  localparam int unsigned BIT_AN_DONE = 5;
  localparam int unsigned BIT_VND_OK  = 12;
  localparam int unsigned BIT_LP_ACK  = 14;
  localparam int unsigned BIT_LP_ABLE = 0;
endpackage

// File: rtl/an_guard_cmd.sv
module an_guard_cmd
  import an_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  guard_st_e          state_i,
  input  logic [DATA_W-1:0]  ctrl_i,
  output logic               req_o,
  output logic               we_o,
  output logic               banked_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  wdata_o
);
  localparam logic [DATA_W-1:0] SET_MASK = (DATA_W'(1) << BIT_AN_EN) | (DATA_W'(1) << BIT_RESTART);
  localparam logic [DATA_W-1:0] CLR_MASK = ~(DATA_W'(1) << BIT_ISO);

  always_comb begin
    req_o    = 1'b1;
    we_o     = 1'b0;
    banked_o = 1'b0;
    bank_o   = '0;
    addr_o   = '0;
    wdata_o  = '0;
    unique case (state_i)
      ST_RD_CTRL: addr_o = ADDR_W'(REG_CTRL);
      ST_RD_STAT: addr_o = ADDR_W'(REG_STAT);
      ST_RD_VND: begin
        banked_o = 1'b1;
        bank_o   = BANK_W'(VND_BANK);
        addr_o   = ADDR_W'(VND_REG);
      end
      ST_RD_LPA:  addr_o = ADDR_W'(REG_LPA);
      ST_RD_EXP:  addr_o = ADDR_W'(REG_EXP);
      ST_WR_CTRL: begin
        we_o    = 1'b1;
        addr_o  = ADDR_W'(REG_CTRL);
        wdata_o = (ctrl_i & CLR_MASK) | SET_MASK;
      end
      default:    req_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/an_guard_eval.sv
module an_guard_eval (
  input  logic vnd_ok_i,
  input  logic lp_ack_i,
  input  logic lp_able_i,
  output logic corrupt_o
);
  always_comb corrupt_o = !vnd_ok_i || (lp_able_i && !lp_ack_i);
endmodule

// File: rtl/an_guard.sv
module an_guard
  import an_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic              mgmt_req_o,
  output logic              mgmt_we_o,
  output logic              mgmt_banked_o,
  output logic [BANK_W-1:0] mgmt_bank_o,
  output logic [ADDR_W-1:0] mgmt_addr_o,
  output logic [DATA_W-1:0] mgmt_wdata_o,
  input  logic              mgmt_ack_i,
  input  logic [DATA_W-1:0] mgmt_rdata_i,
  output logic              restart_o,
  output logic              status_ok_o
);
  guard_st_e         state_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              vnd_ok_q, lp_ack_q, lp_able_q;
  logic              restart_q, ok_q;
  logic              corrupt;
  logic              done;

  an_guard_cmd #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_cmd (
    .state_i  (state_q),
    .ctrl_i   (ctrl_q),
    .req_o    (mgmt_req_o),
    .we_o     (mgmt_we_o),
    .banked_o (mgmt_banked_o),
    .bank_o   (mgmt_bank_o),
    .addr_o   (mgmt_addr_o),
    .wdata_o  (mgmt_wdata_o)
  );

  an_guard_eval u_eval (
    .vnd_ok_i  (vnd_ok_q),
    .lp_ack_i  (lp_ack_q),
    .lp_able_i (lp_able_q),
    .corrupt_o (corrupt)
  );

  assign done = mgmt_req_o && mgmt_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ctrl_q    <= '0;
      vnd_ok_q  <= 1'b0;
      lp_ack_q  <= 1'b0;
      lp_able_q <= 1'b0;
      restart_q <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      ok_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tick_i) state_q <= ST_RD_CTRL;
        ST_RD_CTRL: if (done) begin
          ctrl_q <= mgmt_rdata_i;
          if (mgmt_rdata_i[BIT_AN_EN]) state_q <= ST_RD_STAT;
          else begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b1;
          end
        end
        ST_RD_STAT: if (done) begin
          if (mgmt_rdata_i[BIT_AN_DONE]) state_q <= ST_RD_VND;
          else begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b1;
          end
        end
        ST_RD_VND: if (done) begin
          vnd_ok_q <= mgmt_rdata_i[BIT_VND_OK];
          state_q  <= ST_RD_LPA;
        end
        ST_RD_LPA: if (done) begin
          lp_ack_q <= mgmt_rdata_i[BIT_LP_ACK];
          state_q  <= ST_RD_EXP;
        end
        ST_RD_EXP: if (done) begin
          lp_able_q <= mgmt_rdata_i[BIT_LP_ABLE];
          state_q   <= ST_EVAL;
        end
        ST_EVAL: begin
          if (corrupt) state_q <= ST_WR_CTRL;
          else begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b1;
          end
        end
        ST_WR_CTRL: if (done) begin
          state_q   <= ST_IDLE;
          restart_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign restart_o   = restart_q;
  assign status_ok_o = ok_q;

  assert_one_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_o && status_ok_o));

  assert_quiet_on_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_o || status_ok_o) |-> !mgmt_req_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_req_o && !mgmt_ack_i) |=> (mgmt_req_o && $stable(mgmt_addr_o) && $stable(mgmt_we_o)
      && $stable(mgmt_wdata_o) && $stable(mgmt_banked_o) && $stable(mgmt_bank_o)));

  assert_write_shape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_req_o && mgmt_we_o) |-> (mgmt_addr_o == ADDR_W'(REG_CTRL) && !mgmt_banked_o
      && mgmt_wdata_o[BIT_AN_EN] && mgmt_wdata_o[BIT_RESTART] && !mgmt_wdata_o[BIT_ISO]));

  assert_restart_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restart_o) |-> $past(mgmt_req_o && mgmt_we_o && mgmt_ack_i));

  assert_banked_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_req_o && mgmt_banked_o) |-> (mgmt_bank_o == BANK_W'(VND_BANK)
      && mgmt_addr_o == ADDR_W'(VND_REG) && !mgmt_we_o));
endmodule

// File: tb/an_guard_tb_top.sv
module an_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        restart;
    logic [15:0] wval;
    string       tag;
  } res_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        mgmt_req_o, mgmt_we_o, mgmt_banked_o;
  logic [1:0]  mgmt_bank_o;
  logic [4:0]  mgmt_addr_o;
  logic [15:0] mgmt_wdata_o;
  logic        mgmt_ack_i = 1'b0;
  logic [15:0] mgmt_rdata_i = '0;
  logic        restart_o, status_ok_o;

  int n_checks = 0, n_fail = 0, n_done = 0;
  int latency = 1;
  logic [15:0] phy_ctrl, phy_stat, phy_vnd, phy_lpa, phy_exp, last_wr;
  logic [8:0]  acc_q[$];
  string       acc_tag_q[$];
  res_t        res_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  an_guard dut_i (.*);

  function automatic logic [8:0] enc(input logic we, input logic bk, input logic [1:0] b, input logic [4:0] a);
    return {we, bk, b, a};
  endfunction

  // PHY responder: checks each access against the expected queue
  initial begin
    bit seen = 0;
    int cnt = 0;
    logic [8:0] got, exp_a;
    forever begin
      @(negedge clk_i);
      mgmt_ack_i = 1'b0;
      if (mgmt_req_o && !seen) begin
        seen = 1;
        cnt  = latency;
        got  = enc(mgmt_we_o, mgmt_banked_o, mgmt_bank_o, mgmt_addr_o);
        n_checks++;
        if (acc_q.size() == 0) begin
          n_fail++;
          $display("FAIL R4: unexpected access actual=%h expected=none", got);
        end else begin
          string t;
          exp_a = acc_q.pop_front();
          t = acc_tag_q.pop_front();
          if (got !== exp_a) begin
            n_fail++;
            $display("FAIL %s: access actual=%h expected=%h", t, got, exp_a);
          end
        end
      end
      if (seen) begin
        if (cnt == 0) begin
          mgmt_ack_i = 1'b1;
          seen = 0;
          if (mgmt_we_o) last_wr = mgmt_wdata_o;
          else case ({mgmt_banked_o, mgmt_addr_o})
            6'h00: mgmt_rdata_i = phy_ctrl;
            6'h01: mgmt_rdata_i = phy_stat;
            6'h2c: mgmt_rdata_i = phy_vnd;
            6'h05: mgmt_rdata_i = phy_lpa;
            6'h06: mgmt_rdata_i = phy_exp;
            default: mgmt_rdata_i = 16'hdead;
          endcase
        end else cnt--;
      end
    end
  end

  // Monitor: pops expected results as pulses appear
  initial begin
    forever begin
      @(negedge clk_i);
      if (restart_o || status_ok_o) begin
        n_checks++;
        if (res_q.size() == 0) begin
          n_fail++;
          $display("FAIL R9: extra result actual=%b%b expected=none", restart_o, status_ok_o);
        end else begin
          res_t r;
          r = res_q.pop_front();
          if (restart_o !== r.restart || status_ok_o !== !r.restart) begin
            n_fail++;
            $display("FAIL %s R8: result actual=%b%b expected=%b%b", r.tag, restart_o, status_ok_o, r.restart, !r.restart);
          end
          if (r.restart) begin
            n_checks++;
            if (last_wr !== r.wval) begin
              n_fail++;
              $display("FAIL R7: write actual=%h expected=%h", last_wr, r.wval);
            end
          end
        end
        n_done++;
      end
    end
  end

  task automatic run_check(input string tag, input logic [15:0] c, s, v, l, e,
                           input int lat, input bit extra_tick);
    bit corrupt;
    int target;
    res_t r;
    phy_ctrl = c; phy_stat = s; phy_vnd = v; phy_lpa = l; phy_exp = e;
    latency = lat;
    acc_q.push_back(enc(0, 0, 2'd0, 5'd0)); acc_tag_q.push_back("R1");
    corrupt = 0;
    if (c[12]) begin
      acc_q.push_back(enc(0, 0, 2'd0, 5'd1)); acc_tag_q.push_back("R2");
      if (s[5]) begin
        acc_q.push_back(enc(0, 1, 2'd1, 5'd12)); acc_tag_q.push_back("R3");
        acc_q.push_back(enc(0, 0, 2'd0, 5'd5));  acc_tag_q.push_back("R4");
        acc_q.push_back(enc(0, 0, 2'd0, 5'd6));  acc_tag_q.push_back("R4");
        corrupt = !v[12] || (e[0] && !l[14]);
        if (corrupt) begin
          acc_q.push_back(enc(1, 0, 2'd0, 5'd0)); acc_tag_q.push_back("R7");
        end
      end
    end
    r.restart = corrupt;
    r.wval = (c & ~16'h0400) | 16'h1200;
    r.tag = tag;
    res_q.push_back(r);
    target = n_done + 1;
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
    if (extra_tick) begin
      repeat (2) @(negedge clk_i);
      tick_i = 1'b1;  // R9: arrives mid-check
      @(negedge clk_i); tick_i = 1'b0;
    end
    wait (n_done >= target);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_checks++;  // R11
    if (mgmt_req_o !== 1'b0 || restart_o !== 1'b0 || status_ok_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: reset actual=%b%b%b expected=000", mgmt_req_o, restart_o, status_ok_o);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    n_checks++;  // R11: no activity without tick
    if (mgmt_req_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: idle req actual=%b expected=0", mgmt_req_o);
    end
    // R10: latencies 0..3 exercise the request hold
    run_check("R2", 16'h0000, 16'h0020, 16'h1000, 16'h4000, 16'h0001, 0, 0);
    run_check("R2", 16'h0100, 16'h0020, 16'h0000, 16'h0000, 16'h0001, 2, 0);
    run_check("R3", 16'h1000, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 1, 0);
    run_check("R8", 16'h1000, 16'h0024, 16'h1000, 16'h4000, 16'h0001, 3, 0);
    run_check("R5", 16'h1000, 16'h0020, 16'hefff, 16'h4000, 16'h0001, 1, 0);
    run_check("R6", 16'h1000, 16'h0020, 16'h1000, 16'hbfff, 16'h0001, 0, 0);
    run_check("R6", 16'h1000, 16'h0020, 16'h1000, 16'h0000, 16'hfffe, 2, 0);
    run_check("R7", 16'h1c40, 16'h0020, 16'h0000, 16'h4000, 16'h0000, 1, 0);
    run_check("R7", 16'h1fff, 16'hffff, 16'h0000, 16'h0000, 16'h0001, 0, 0);
    run_check("R9", 16'h1000, 16'h0020, 16'h1000, 16'h4000, 16'h0000, 3, 1);
    run_check("R9", 16'h1000, 16'h0020, 16'h0000, 16'h4000, 16'h0000, 2, 1);
    repeat (20) @(negedge clk_i);
    n_checks++;  // R9: nothing left outstanding
    if (acc_q.size() != 0 || res_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9: pending actual=%0d/%0d expected=0/0", acc_q.size(), res_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule